// File: doc/BRIEF.md
# Link Power Request Controller

This block decides when a serial storage link should change power state (Active, Partial, Slumber, DevSleep) and hands exactly one transition request at a time to the link layer. Software writes a small control word whose low nibble is a power request. The controller vets the request against the link's present state and a strap, forwards it only when the link reports idle, and lets the request nibble fall back to zero once the request is dealt with.

Two hardware-initiated paths sit beside the software path. The first, aggressive entry, starts a low-power move when the final outstanding bit of the command-issue vector or the active-tag vector drops and both vectors are empty. The second, automatic promotion, moves a link that has stayed idle in Partial for a programmable dwell on to Slumber. A request stays on the output, with its target unchanged, until the link acknowledges it.

Top module: `lpm_req_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `xfer_req` is 0 and `rd_data` reads 0x00.
- R2: A non-zero request write is taken only if `link_idle` is 1 and no request is outstanding. Otherwise it changes neither `xfer_req`, `xfer_target` nor the request nibble of `rd_data`.
- R3: The control word layout is bits [3:0] request, bit 4 aggressive enable, bit 5 aggressive target select, bit 6 automatic promotion enable, bit 7 reads 0. Link state codes are 0 Active, 1 Partial, 2 Slumber, 3 DevSleep. An accepted request raises `xfer_req` one cycle after the write, with `xfer_target` set to the state code and `rd_data[3:0]` holding the code written. When `xfer_ack` is sampled high, `xfer_req` and `rd_data[3:0]` are 0 in the next cycle.
- R4: A request for the state the link is already in starts no transition and leaves `rd_data[3:0]` at 0.
- R5: A request from one low-power state to a different low-power state other than DevSleep is refused, with the nibble left at 0. The link must return to Active first.
- R6: With `strap_dsl_slumber_only` at 0, DevSleep is accepted from Active, Partial and Slumber. With the strap at 1, it is accepted only from Slumber.
- R7: Request codes are 1 Active, 2 Partial, 6 Slumber and 8 DevSleep. Any other non-zero code is ignored, with the nibble left at 0.
- R8: With aggressive entry enabled, the link Active and idle, and nothing outstanding, a cycle in which a bit of `cmd_issue` or `cmd_active` clears and both vectors are then zero raises a request one cycle later. Select bit 1 targets Slumber (2) and select bit 0 targets Partial (1).
- R9: With `strap_lpm_cap` at 0, the aggressive enable and select bits read 0 and have no effect.
- R10: With promotion enabled, a request to Slumber is raised after the link has been in Partial, idle, for `P2S_DWELL`+1 consecutive clock edges. Any edge that fails this condition restarts the count.
- R11: Only one request is outstanding at a time. While `xfer_req` is high and not acknowledged, `xfer_target` stays stable and new requests are ignored.
- R12: When sources compete in the same cycle, a software request beats aggressive entry, and aggressive entry beats automatic promotion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word written |
| link_idle | input | 1 | Link layer is idle |
| link_state | input | 2 | Current link power state code |
| strap_lpm_cap | input | 1 | Aggressive power management capability |
| strap_dsl_slumber_only | input | 1 | DevSleep only allowed from Slumber |
| cmd_issue | input | NSLOT | Command-issue vector |
| cmd_active | input | NSLOT | Active-tag vector |
| xfer_req | output | 1 | Transition request to the link layer |
| xfer_target | output | 2 | Requested state code |
| xfer_ack | input | 1 | Link layer acknowledges the request |
| rd_data | output | 8 | Control word readback |

## Verification
The bench builds the block with NSLOT = 8 and P2S_DWELL = 4. With eight slots, random bit clears drain both vectors to zero often, so aggressive entry fires many times in the random phase rather than almost never. A four-cycle dwell lets promotion to Slumber complete inside short random stretches in Partial, and it also lets the directed test count the exact number of edges before promotion.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      LNK_ACTIVE  = 2'd0,
      LNK_PARTIAL = 2'd1,
      LNK_SLUMBER = 2'd2,
      LNK_DEVSLP  = 2'd3
   } lnk_st_e;

   localparam int unsigned REQ_W  = 4;
   localparam int unsigned CTRL_W = 8;

   localparam logic [REQ_W-1:0] RQ_NOP     = 4'd0;
   localparam logic [REQ_W-1:0] RQ_ACTIVE  = 4'd1;
   localparam logic [REQ_W-1:0] RQ_PARTIAL = 4'd2;
   localparam logic [REQ_W-1:0] RQ_SLUMBER = 4'd6;
   localparam logic [REQ_W-1:0] RQ_DEVSLP  = 4'd8;

   localparam int unsigned BIT_AGGR_EN  = 4;
   localparam int unsigned BIT_AGGR_SEL = 5;
   localparam int unsigned BIT_P2S_EN   = 6;

endpackage

// File: rtl/lpm_req_decode.sv
module lpm_req_decode
   import lpm_pkg::*;
(
   input  logic [REQ_W-1:0] req_code,
   input  logic [1:0]       cur_state,
   input  logic             dsl_slumber_only,
   output logic             legal,
   output logic [1:0]       target
);

   logic    known;
   lnk_st_e tgt_e;
   lnk_st_e cur_e;

   assign cur_e = lnk_st_e'(cur_state);

   always_comb begin
      known = 1'b1;
      tgt_e = LNK_ACTIVE;
      unique case (req_code)
         RQ_ACTIVE:  tgt_e = LNK_ACTIVE;
         RQ_PARTIAL: tgt_e = LNK_PARTIAL;
         RQ_SLUMBER: tgt_e = LNK_SLUMBER;
         RQ_DEVSLP:  tgt_e = LNK_DEVSLP;
         default:    known = 1'b0;
      endcase
   end

   logic same_state;
   logic lp_hop;
   logic dsl_block;

   assign same_state = (tgt_e == cur_e);
   assign lp_hop     = (cur_e != LNK_ACTIVE) && (tgt_e != LNK_ACTIVE) && (tgt_e != LNK_DEVSLP);
   assign dsl_block  = (tgt_e == LNK_DEVSLP) && dsl_slumber_only && (cur_e != LNK_SLUMBER);

   assign legal  = known && !same_state && !lp_hop && !dsl_block;
   assign target = tgt_e;

endmodule

// File: rtl/lpm_drain_detect.sv
module lpm_drain_detect #(
   parameter int unsigned NSLOT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] cmd_issue,
   input  logic [NSLOT-1:0] cmd_active,
   output logic             drain_evt
);

   if (NSLOT < 1 || NSLOT > 32) begin : g_bad_nslot
      $error("lpm_drain_detect: NSLOT must lie in 1..32");
   end

   logic [NSLOT-1:0] issue_q;
   logic [NSLOT-1:0] active_q;
   logic [NSLOT-1:0] fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_q  <= '0;
         active_q <= '0;
      end else begin
         issue_q  <= cmd_issue;
         active_q <= cmd_active;
      end
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_fell
      assign fell[i] = (issue_q[i] && !cmd_issue[i]) || (active_q[i] && !cmd_active[i]);
   end

   assign drain_evt = (|fell) && (cmd_issue == '0) && (cmd_active == '0);

endmodule

// File: rtl/lpm_p2s_timer.sv
module lpm_p2s_timer #(
   parameter int unsigned DWELL = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qualify,
   output logic promote
);

   if (DWELL > 65535) begin : g_bad_dwell
      $error("lpm_p2s_timer: DWELL must not exceed 65535");
   end

   if (DWELL == 0) begin : g_immediate
      assign promote = qualify;
   end else begin : g_counted
      localparam int unsigned CW = $clog2(DWELL + 1);
      localparam logic [CW-1:0] LIMIT = CW'(DWELL);

      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!qualify) begin
            cnt_q <= '0;
         end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign promote = qualify && (cnt_q == LIMIT);

      a_r10_count_bounded : assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LIMIT);
   end

endmodule

// File: rtl/lpm_req_ctrl.sv
module lpm_req_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned NSLOT     = 32,
   parameter int unsigned P2S_DWELL = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              link_idle,
   input  logic [1:0]        link_state,
   input  logic              strap_lpm_cap,
   input  logic              strap_dsl_slumber_only,
   input  logic [NSLOT-1:0]  cmd_issue,
   input  logic [NSLOT-1:0]  cmd_active,
   output logic              xfer_req,
   output logic [1:0]        xfer_target,
   input  logic              xfer_ack,
   output logic [7:0]        rd_data
);

   if (CTRL_W != 8) begin : g_bad_ctrl
      $error("lpm_req_ctrl: control word must be 8 bits");
   end

   logic [REQ_W-1:0] wr_req;
   assign wr_req = wr_data[REQ_W-1:0];

   logic             pend_q;
   logic [1:0]       tgt_q;
   logic [REQ_W-1:0] field_q;
   logic             aggr_en_q;
   logic             aggr_sel_q;
   logic             p2s_en_q;

   logic       dec_legal;
   logic [1:0] dec_tgt;

   lpm_req_decode u_decode (
      .req_code         (wr_req),
      .cur_state        (link_state),
      .dsl_slumber_only (strap_dsl_slumber_only),
      .legal            (dec_legal),
      .target           (dec_tgt)
   );

   logic drain_evt;

   lpm_drain_detect #(.NSLOT(NSLOT)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_issue  (cmd_issue),
      .cmd_active (cmd_active),
      .drain_evt  (drain_evt)
   );

   logic p2s_qual;
   logic p2s_fire;

   assign p2s_qual = (lnk_st_e'(link_state) == LNK_PARTIAL) && p2s_en_q && link_idle;

   lpm_p2s_timer #(.DWELL(P2S_DWELL)) u_p2s (
      .clk     (clk),
      .rst_n   (rst_n),
      .qualify (p2s_qual),
      .promote (p2s_fire)
   );

   logic aggr_on;
   logic sel_on;
   logic take_sw;
   logic take_aggr;
   logic take_p2s;

   assign aggr_on   = aggr_en_q && strap_lpm_cap;
   assign sel_on    = aggr_sel_q && strap_lpm_cap;
   assign take_sw   = wr_en && (wr_req != RQ_NOP) && link_idle && !pend_q && dec_legal;
   assign take_aggr = drain_evt && aggr_on && link_idle && !pend_q && !take_sw &&
                      (lnk_st_e'(link_state) == LNK_ACTIVE);
   assign take_p2s  = p2s_fire && !pend_q && !take_sw && !take_aggr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         tgt_q   <= LNK_ACTIVE;
         field_q <= RQ_NOP;
      end else if (take_sw) begin
         pend_q  <= 1'b1;
         tgt_q   <= dec_tgt;
         field_q <= wr_req;
      end else if (take_aggr) begin
         pend_q  <= 1'b1;
         tgt_q   <= sel_on ? LNK_SLUMBER : LNK_PARTIAL;
      end else if (take_p2s) begin
         pend_q  <= 1'b1;
         tgt_q   <= LNK_SLUMBER;
      end else if (pend_q && xfer_ack) begin
         pend_q  <= 1'b0;
         field_q <= RQ_NOP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aggr_en_q  <= 1'b0;
         aggr_sel_q <= 1'b0;
         p2s_en_q   <= 1'b0;
      end else if (wr_en) begin
         aggr_en_q  <= wr_data[BIT_AGGR_EN];
         aggr_sel_q <= wr_data[BIT_AGGR_SEL];
         p2s_en_q   <= wr_data[BIT_P2S_EN];
      end
   end

   assign xfer_req    = pend_q;
   assign xfer_target = tgt_q;
   assign rd_data     = {1'b0, p2s_en_q, sel_on, aggr_on, field_q};

   // R2: nothing can start while the link is busy
   a_r2_no_req_when_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (!link_idle && !xfer_req) |=> !xfer_req);

   // R3: acknowledge retires the request and clears the nibble
   a_r3_ack_retires : assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_ack) |=> (!xfer_req && rd_data[3:0] == 4'd0));

   // R3: no software code visible without a request in flight
   a_r3_field_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req |-> (rd_data[3:0] == 4'd0));

   // R4: a new request never targets the state the link was in
   a_r4_no_self_move : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_req) |-> (xfer_target != $past(link_state)));

   // R5: only promotion may go from one low-power state to another (besides DevSleep)
   a_r5_no_lp_hop : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xfer_req) && $past(link_state) != 2'd0 && xfer_target != 2'd0 &&
       xfer_target != 2'd3)
      |-> ($past(link_state) == 2'd1 && xfer_target == 2'd2));

   // R6: strapped DevSleep entry only from Slumber
   a_r6_dsl_from_slumber : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xfer_req) && xfer_target == 2'd3 && $past(strap_dsl_slumber_only))
      |-> ($past(link_state) == 2'd2));

   // R11: request and target held until acknowledged
   a_r11_hold_until_ack : assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_target)));

endmodule

// File: tb/lpm_req_ctrl_tb.sv
module lpm_req_ctrl_tb;

   localparam int unsigned NSLOT = 8;
   localparam int unsigned DW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [7:0]       wr_data = '0;
   logic             link_idle = 1'b1;
   logic [1:0]       link_state = 2'd0;
   logic             cap = 1'b1;
   logic             dsl_only = 1'b0;
   logic [NSLOT-1:0] ci = '0;
   logic [NSLOT-1:0] tag = '0;
   logic             xfer_req;
   logic [1:0]       xfer_target;
   logic             xfer_ack = 1'b0;
   logic [7:0]       rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_en = 1'b0;

   always #2.5 clk = ~clk;

   lpm_req_ctrl #(.NSLOT(NSLOT), .P2S_DWELL(DW)) u_dut (
      .clk                    (clk),
      .rst_n                  (rst_n),
      .wr_en                  (wr_en),
      .wr_data                (wr_data),
      .link_idle              (link_idle),
      .link_state             (link_state),
      .strap_lpm_cap          (cap),
      .strap_dsl_slumber_only (dsl_only),
      .cmd_issue              (ci),
      .cmd_active             (tag),
      .xfer_req               (xfer_req),
      .xfer_target            (xfer_target),
      .xfer_ack               (xfer_ack),
      .rd_data                (rd_data)
   );

   // expected decision for a software code: {accept, target}
   function automatic logic [2:0] ref_decide(logic [3:0] c, logic [1:0] cur, logic donly);
      logic       v;
      logic [1:0] t;
      v = 1'b1;
      case (c)
         4'd1: t = 2'd0;
         4'd2: t = 2'd1;
         4'd6: t = 2'd2;
         4'd8: t = 2'd3;
         default: begin v = 1'b0; t = 2'd0; end
      endcase
      if (t == cur) v = 1'b0;
      if (cur != 2'd0 && t != 2'd0 && t != 2'd3) v = 1'b0;
      if (t == 2'd3 && donly && cur != 2'd2) v = 1'b0;
      return {v, t};
   endfunction

   // reference state
   logic             m_pend, m_aggr, m_sel, m_p2s;
   logic [1:0]       m_tgt;
   logic [3:0]       m_req;
   logic [NSLOT-1:0] m_pci, m_ptag;
   int               m_cnt;
   logic [2:0]       m_dec;
   logic             m_tsw, m_tag, m_tp2, m_ev, m_cond;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_aggr = 0; m_sel = 0; m_p2s = 0; m_tgt = 0; m_req = 0;
         m_pci = '0; m_ptag = '0; m_cnt = 0;
      end else begin
         m_dec  = ref_decide(wr_data[3:0], link_state, dsl_only);
         m_tsw  = wr_en && wr_data[3:0] != 0 && link_idle && !m_pend && m_dec[2];
         m_ev   = (((m_pci & ~ci) | (m_ptag & ~tag)) != '0) && ci == '0 && tag == '0;
         m_tag  = m_ev && m_aggr && cap && link_state == 2'd0 && link_idle && !m_pend && !m_tsw;
         m_cond = link_state == 2'd1 && m_p2s && link_idle;
         m_tp2  = m_cond && m_cnt == DW && !m_pend && !m_tsw && !m_tag;
         if (m_tsw) begin
            m_pend = 1; m_tgt = m_dec[1:0]; m_req = wr_data[3:0];
         end else if (m_tag) begin
            m_pend = 1; m_tgt = (m_sel && cap) ? 2'd2 : 2'd1;
         end else if (m_tp2) begin
            m_pend = 1; m_tgt = 2'd2;
         end else if (m_pend && xfer_ack) begin
            m_pend = 0; m_req = 0;
         end
         if (!m_cond) m_cnt = 0;
         else if (m_cnt != DW) m_cnt = m_cnt + 1;
         if (wr_en) begin
            m_aggr = wr_data[4]; m_sel = wr_data[5]; m_p2s = wr_data[6];
         end
         m_pci = ci; m_ptag = tag;
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", rq, act, exp, $time);
      end
   endtask

   // continuous comparison against the reference (R3, R11 on every cycle)
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         chk(xfer_req == m_pend, "R11 model xfer_req", int'(xfer_req), int'(m_pend));
         if (m_pend)
            chk(xfer_target == m_tgt, "R3 model target", int'(xfer_target), int'(m_tgt));
         chk(rd_data == {1'b0, m_p2s, m_sel & cap, m_aggr & cap, m_req}, "R3 model readback",
             int'(rd_data), int'({1'b0, m_p2s, m_sel & cap, m_aggr & cap, m_req}));
      end
   end

   task automatic do_reset(input logic c, input logic d);
      @(negedge clk); #1;
      cmp_en = 0; rst_n = 0; cap = c; dsl_only = d;
      wr_en = 0; xfer_ack = 0; ci = '0; tag = '0; link_state = 2'd0; link_idle = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1 cmp_en = 1;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic ack_link();
      @(negedge clk);
      xfer_ack = 1; link_state = xfer_target;
      @(negedge clk);
      xfer_ack = 0;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset(1'b1, 1'b0);
      // R1: reset state
      chk(xfer_req == 0, "R1 xfer_req after reset", int'(xfer_req), 0);
      chk(rd_data == 8'h00, "R1 readback after reset", int'(rd_data), 0);

      // R3: Active -> Partial
      wr(8'h02);
      chk(xfer_req == 1, "R3 req raised", int'(xfer_req), 1);
      chk(xfer_target == 2'd1, "R3 target partial", int'(xfer_target), 1);
      chk(rd_data[3:0] == 4'd2, "R3 nibble holds code", int'(rd_data[3:0]), 2);
      // R11: second request ignored while pending
      wr(8'h06);
      chk(xfer_target == 2'd1 && rd_data[3:0] == 4'd2, "R11 pending ignores write",
          int'({xfer_target, rd_data[3:0]}), int'({2'd1, 4'd2}));
      ack_link();
      chk(xfer_req == 0 && rd_data[3:0] == 0, "R3 ack retires", int'({xfer_req, rd_data[3:0]}), 0);

      // R5: Partial -> Slumber refused
      wr(8'h06);
      chk(xfer_req == 0 && rd_data[3:0] == 0, "R5 low-power hop refused", int'(xfer_req), 0);
      // R4: same state
      wr(8'h02);
      chk(xfer_req == 0 && rd_data[3:0] == 0, "R4 same state no move", int'(xfer_req), 0);
      // R6: DevSleep from Partial with strap 0
      wr(8'h08);
      chk(xfer_req == 1 && xfer_target == 2'd3, "R6 devsleep from partial", int'(xfer_target), 3);
      ack_link();
      // R7: code 1 returns to Active
      wr(8'h01);
      chk(xfer_req == 1 && xfer_target == 2'd0, "R7 active code", int'(xfer_target), 0);
      ack_link();

      // R2: link busy
      link_idle = 0;
      wr(8'h02);
      chk(xfer_req == 0 && rd_data[3:0] == 0, "R2 busy write ignored", int'(xfer_req), 0);
      link_idle = 1;
      // R7: reserved code
      wr(8'h03);
      chk(xfer_req == 0 && rd_data[3:0] == 0, "R7 reserved code ignored", int'(rd_data), 0);

      // R6: strap 1
      do_reset(1'b1, 1'b1);
      wr(8'h08);
      chk(xfer_req == 0, "R6 devsleep refused from active", int'(xfer_req), 0);
      wr(8'h06);
      ack_link();
      wr(8'h08);
      chk(xfer_req == 1 && xfer_target == 2'd3, "R6 devsleep from slumber", int'(xfer_target), 3);
      ack_link();
      wr(8'h01);
      ack_link();

      // R8: aggressive entry to Partial
      do_reset(1'b1, 1'b0);
      wr(8'h10);
      chk(rd_data == 8'h10, "R3 aggressive bit readback", int'(rd_data), 8'h10);
      @(negedge clk); ci = 8'h05;
      @(negedge clk); ci = 8'h04;
      @(negedge clk);
      chk(xfer_req == 0, "R8 partial drain no entry", int'(xfer_req), 0);
      ci = 8'h00;
      @(negedge clk);
      chk(xfer_req == 1 && xfer_target == 2'd1, "R8 entry to partial", int'(xfer_target), 1);
      ack_link();
      wr(8'h11);
      ack_link();
      // R8: select -> Slumber
      wr(8'h30);
      @(negedge clk); tag = 8'h80;
      @(negedge clk); tag = 8'h00;
      @(negedge clk);
      chk(xfer_req == 1 && xfer_target == 2'd2, "R8 entry to slumber", int'(xfer_target), 2);
      ack_link();
      wr(8'h31);
      ack_link();

      // R12: software beats aggressive
      @(negedge clk); tag = 8'h01;
      @(negedge clk);
      tag = 8'h00; wr_en = 1; wr_data = 8'h18;
      @(negedge clk); wr_en = 0;
      chk(xfer_req == 1 && xfer_target == 2'd3, "R12 software wins", int'(xfer_target), 3);
      ack_link();
      wr(8'h01);
      ack_link();

      // R9: capability off
      do_reset(1'b0, 1'b0);
      wr(8'h30);
      chk(rd_data == 8'h00, "R9 aggressive bits read 0", int'(rd_data), 0);
      @(negedge clk); tag = 8'h01;
      @(negedge clk); tag = 8'h00;
      @(negedge clk);
      chk(xfer_req == 0, "R9 no aggressive entry", int'(xfer_req), 0);

      // R10: promotion after dwell
      do_reset(1'b1, 1'b0);
      wr(8'h42);
      ack_link();
      begin
         int k;
         k = 0;
         while (!xfer_req && k < 50) begin
            @(negedge clk);
            k++;
         end
         chk(k == DW, "R10 promotion edge count", k, DW);
         chk(xfer_target == 2'd2, "R10 promotion target", int'(xfer_target), 2);
      end
      ack_link();

      // random phase, checked against the reference
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (i == 2000) begin
            do_reset(1'b1, 1'b1);
            @(negedge clk);
         end
         link_idle = ($urandom % 5) != 0;
         if (xfer_req && ($urandom % 3) == 0) begin
            xfer_ack = 1; link_state = xfer_target;
         end else begin
            xfer_ack = 0;
         end
         wr_en = ($urandom % 6) == 0;
         begin
            logic [3:0] codes [6];
            codes = '{4'd1, 4'd2, 4'd6, 4'd8, 4'd0, 4'd0};
            wr_data[3:0] = (($urandom % 8) == 0) ? 4'($urandom) : codes[$urandom % 6];
            wr_data[7:4] = {1'b0, 3'($urandom)};
         end
         case ($urandom % 8)
            0: ci  = ci  | NSLOT'(1 << ($urandom % NSLOT));
            1: tag = tag | NSLOT'(1 << ($urandom % NSLOT));
            2, 3: ci  = ci  & ~NSLOT'(1 << ($urandom % NSLOT));
            4, 5: tag = tag & ~NSLOT'(1 << ($urandom % NSLOT));
            default: ;
         endcase
      end
      @(negedge clk);
      wr_en = 0; xfer_ack = 0;
      repeat (2) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule